// File: doc/BRIEF.md
# Serial Control Byte Register Slave

This block is a two-wire serial bus slave that receives one control byte per write transaction and holds it in an 8-bit register that steers a card-interface controller. The bus lines are brought into the system clock domain through a two-flop synchronizer. A falling data line while the clock line is high marks the start of a frame, and a rising data line while the clock line is high marks its end. The first byte must carry the slave's 7-bit address with the write direction. If it does, the slave pulls the data line low for the acknowledge clock, takes in the next byte, acknowledges it, and commits it to the register.

Each register bit drives one control output. The warm-reset request bit clears itself. Once that bit is set, a card-answer or card-mute event arms a pending flag, and a later status-read strobe clears the bit. Read transactions, multi-byte bursts and clock stretching are not supported.

Top module: `ctl_byte_slave`

## Requirements
- R1: After reset all eight register bits and every control output are 0, and the slave does not pull the data line low.
- R2: A falling data line while the clock line is high starts a frame, including a repeated start in mid-frame. A rising data line while the clock line is high ends it.
- R3: The first byte is received MSB first. The slave acknowledges it during the ninth clock only when its upper seven bits equal the address parameter and bit 0 (direction) is 0. Any other first byte gets no acknowledge and leaves the register unchanged.
- R4: After an acknowledged address, the second byte is received MSB first and acknowledged. It is written to the register at the rising clock edge of that acknowledge, so the new value is already visible while the acknowledge clock is high.
- R5: A stop or repeated start that comes before the second acknowledge discards the partial byte, and the register keeps its value.
- R6: The register bits map to the outputs as follows. Bit 0 is the activation request (1 = activate with cold reset, 0 = deactivate). Bit 1 is the warm-reset request. Bit 2 is the supply select (1 = 3 V, 0 = 5 V). Bit 3 is power-down. Bit 4 is the clock-stop level (1 = high). Bits 6:5 are the clock divider select (00 = /8, 01 = /4, 10 = /2, 11 = /1). Bit 7 is the data-path enable.
- R7: While bit 1 is set, a card-answer or card-mute pulse arms a pending flag. A status-read strobe clears bit 1 only when that flag is armed. A status read without an earlier event, or an event alone, leaves bit 1 set. A bus write overrides all of this.
- R8: Bytes that follow the control byte in the same frame get no acknowledge and do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_low_o | output | 1 | 1 = pull the data line low (acknowledge) |
| card_answer_i | input | 1 | Pulse: the card has begun answering |
| card_mute_i | input | 1 | Pulse: the card has been declared mute |
| status_read_i | input | 1 | Pulse: the host has read the status |
| act_req_o | output | 1 | Activation request (register bit 0) |
| warm_req_o | output | 1 | Warm-reset request (register bit 1) |
| vsel_3v_o | output | 1 | Supply select, 1 = 3 V (register bit 2) |
| pwr_down_o | output | 1 | Power-down (register bit 3) |
| clk_stop_high_o | output | 1 | Clock-stop level in power-down (register bit 4) |
| clk_div_sel_o | output | 2 | Card clock divider select (register bits 6:5) |
| data_en_o | output | 1 | Data-path enable (register bit 7) |

## Verification
A bus edge reaches the edge detector after the two synchronizer flops. An acknowledge therefore appears about four system cycles after the falling edge of the eighth clock, and a committed byte shows on the outputs about four cycles after the acknowledge clock rises. The bench holds every bus phase for ten system cycles. It samples the acknowledge and the committed value six cycles into the high phase of the ninth clock, and it checks the other register values only after the stop condition has fully settled. The handshake strobes act after one register stage, so their results are sampled two cycles after each pulse.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int CTRL_W = 8;

    localparam int B_ACT   = 0;
    localparam int B_WARM  = 1;
    localparam int B_VSEL  = 2;
    localparam int B_PDOWN = 3;
    localparam int B_STOPH = 4;
    localparam int B_DIV_L = 5;
    localparam int B_DIV_H = 6;
    localparam int B_DEN   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_HOLD
    } bus_st_e;
endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int CUR = STAGES - 1;
    localparam int PRV = STAGES;

    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.scl = {sync_q.scl[STAGES-1:0], scl_i};
        sync_d.sda = {sync_q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign sda_o      = sync_q.sda[CUR];
    assign scl_rise_o = sync_q.scl[CUR] & ~sync_q.scl[PRV];
    assign scl_fall_o = ~sync_q.scl[CUR] & sync_q.scl[PRV];
    assign start_o    = sync_q.scl[CUR] & sync_q.scl[PRV] & sync_q.sda[PRV] & ~sync_q.sda[CUR];
    assign stop_o     = sync_q.scl[CUR] & sync_q.scl[PRV] & ~sync_q.sda[PRV] & sync_q.sda[CUR];

    p_no_frame_edge_on_clock_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise_o || scl_fall_o) |-> !(start_o || stop_o));
endmodule

// File: rtl/ctl_bus_fsm.sv
module ctl_bus_fsm
    import ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h24,
    parameter int         W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_i,
    input  logic         scl_rise_i,
    input  logic         scl_fall_i,
    input  logic         start_i,
    input  logic         stop_i,
    output logic         sda_low_o,
    output logic         wr_en_o,
    output logic [W-1:0] wr_data_o
);
    localparam int             CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
    localparam logic [W-1:0]   MATCH = {DEV_ADDR, 1'b0};

    typedef struct packed {
        bus_st_e          state;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     shreg;
        logic             ack;
    } fsm_t;

    fsm_t f_d, f_q;
    logic wr_en;

    always_comb begin
        f_d   = f_q;
        wr_en = 1'b0;
        if (stop_i) begin
            f_d.state = ST_IDLE;
            f_d.ack   = 1'b0;
        end else if (start_i) begin
            f_d.state = ST_ADDR;
            f_d.cnt   = '0;
            f_d.ack   = 1'b0;
        end else begin
            unique case (f_q.state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise_i && f_q.cnt != FULL) begin
                        f_d.shreg = {f_q.shreg[W-2:0], sda_i};
                        f_d.cnt   = f_q.cnt + 1'b1;
                    end
                    if (scl_fall_i && f_q.cnt == FULL) begin
                        if (f_q.state == ST_DATA) begin
                            f_d.state = ST_DACK;
                            f_d.ack   = 1'b1;
                        end else if (f_q.shreg == MATCH) begin
                            f_d.state = ST_AACK;
                            f_d.ack   = 1'b1;
                        end else begin
                            f_d.state = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        f_d.state = ST_DATA;
                        f_d.cnt   = '0;
                        f_d.ack   = 1'b0;
                    end
                end
                ST_DACK: begin
                    if (scl_rise_i) wr_en = 1'b1;
                    if (scl_fall_i) begin
                        f_d.state = ST_HOLD;
                        f_d.ack   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, ack: 1'b0};
        else        f_q <= f_d;
    end

    assign sda_low_o = f_q.ack;
    assign wr_en_o   = wr_en;
    assign wr_data_o = f_q.shreg;

    p_ack_only_in_ack_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> (f_q.state == ST_AACK || f_q.state == ST_DACK));
    p_start_restarts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (f_q.state == ST_ADDR && f_q.cnt == '0));
    p_commit_after_full_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (f_q.cnt == FULL && sda_low_o));
    p_stop_releases_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (f_q.state == ST_IDLE && !sda_low_o));
    p_hold_never_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_HOLD && !start_i) |=> !sda_low_o);
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
    import ctl_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         card_answer_i,
    input  logic         card_mute_i,
    input  logic         status_read_i,
    output logic [W-1:0] ctrl_o
);
    typedef struct packed {
        logic [W-1:0] ctrl;
        logic         pend;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            r_d.ctrl = wr_data_i;
            r_d.pend = 1'b0;
        end else begin
            if ((card_answer_i || card_mute_i) && r_q.ctrl[B_WARM])
                r_d.pend = 1'b1;
            if (status_read_i && r_q.pend) begin
                r_d.ctrl[B_WARM] = 1'b0;
                r_d.pend         = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;

    p_write_loads_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ctrl_o == $past(wr_data_i));
    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(ctrl_o[W-1:2]) && $stable(ctrl_o[0])));
    p_warm_clear_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[B_WARM] && !wr_en_i && !(status_read_i && r_q.pend)) |=> ctrl_o[B_WARM]);
endmodule

// File: rtl/ctl_byte_slave.sv
module ctl_byte_slave
    import ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h24,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_low_o,
    input  logic       card_answer_i,
    input  logic       card_mute_i,
    input  logic       status_read_i,
    output logic       act_req_o,
    output logic       warm_req_o,
    output logic       vsel_3v_o,
    output logic       pwr_down_o,
    output logic       clk_stop_high_o,
    output logic [1:0] clk_div_sel_o,
    output logic       data_en_o
);
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_en;
    logic [CTRL_W-1:0] wr_data, ctrl;

    ctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    ctl_bus_fsm #(.DEV_ADDR(DEV_ADDR), .W(CTRL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_s), .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
        .sda_low_o(sda_pull_low_o), .wr_en_o(wr_en), .wr_data_o(wr_data)
    );

    ctl_reg_file #(.W(CTRL_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .card_answer_i(card_answer_i), .card_mute_i(card_mute_i),
        .status_read_i(status_read_i), .ctrl_o(ctrl)
    );

    assign act_req_o       = ctrl[B_ACT];
    assign warm_req_o      = ctrl[B_WARM];
    assign vsel_3v_o       = ctrl[B_VSEL];
    assign pwr_down_o      = ctrl[B_PDOWN];
    assign clk_stop_high_o = ctrl[B_STOPH];
    assign clk_div_sel_o   = ctrl[B_DIV_H:B_DIV_L];
    assign data_en_o       = ctrl[B_DEN];

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl == '0 && !sda_pull_low_o));
endmodule

// File: tb/test_ctl_byte_slave.sv
module test_ctl_byte_slave;
    localparam logic [6:0] ADDR = 7'h24;
    localparam int Q = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_host = 1'b1;
    logic ans = 1'b0, mute = 1'b0, sread = 1'b0;
    logic sda_low, act, warm, v3, pd, sth, den;
    logic [1:0] div;
    logic sda_line;
    int checks = 0, fails = 0;
    bit done = 0;

    assign sda_line = sda_host & ~sda_low;

    always #10 clk = ~clk;

    ctl_byte_slave #(.DEV_ADDR(ADDR)) i_ctl_byte_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_low_o(sda_low), .card_answer_i(ans), .card_mute_i(mute),
        .status_read_i(sread), .act_req_o(act), .warm_req_o(warm),
        .vsel_3v_o(v3), .pwr_down_o(pd), .clk_stop_high_o(sth),
        .clk_div_sel_o(div), .data_en_o(den)
    );

    function automatic logic [7:0] outs();
        return {den, div, sth, pd, v3, warm, act};
    endfunction

    task automatic check(input string req, input logic [31:0] actv, input logic [31:0] expv);
        checks++;
        if (actv !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actv, expv);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; waitc(Q); scl = 1'b1; waitc(Q);
        sda_host = 1'b0; waitc(Q); scl = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
        sda_host = 1'b1; waitc(2 * Q);
    endtask

    task automatic bus_bit(input logic b);
        sda_host = b; waitc(Q); scl = 1'b1; waitc(Q); scl = 1'b0; waitc(Q);
    endtask

    task automatic bus_ack(output logic acked, output logic [7:0] seen);
        sda_host = 1'b1; waitc(Q); scl = 1'b1; waitc(6);
        acked = ~sda_line; seen = outs();
        waitc(Q - 6); scl = 1'b0; waitc(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic acked, output logic [7:0] seen);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_ack(acked, seen);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; waitc(1); s = 1'b0; waitc(2);
    endtask

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] data;
        logic       ack;
        logic [7:0] expv;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h24, 8'hA5, 1'b1, 8'hA5},
        '{7'h24, 8'h3C, 1'b1, 8'h3C},
        '{7'h25, 8'hFF, 1'b0, 8'h3C},
        '{7'h24, 8'h00, 1'b1, 8'h00},
        '{7'h24, 8'h81, 1'b1, 8'h81},
        '{7'h14, 8'h7E, 1'b0, 8'h81},
        '{7'h24, 8'h5A, 1'b1, 8'h5A}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a1, a2;
        logic [7:0] s1, s2;
        waitc(5);
        check("R1 reset outputs", outs(), 8'h00);
        check("R1 reset no pull", sda_low, 1'b0);
        rst_n = 1'b1; waitc(5);
        check("R1 after release", outs(), 8'h00);

        // R3 R4 R6 table walk
        foreach (VECS[k]) begin
            bus_start();
            bus_byte({VECS[k].addr, 1'b0}, a1, s1);
            bus_byte(VECS[k].data, a2, s2);
            check("R3 address ack", a1, VECS[k].ack);
            check("R4 data ack", a2, VECS[k].ack);
            if (VECS[k].ack) check("R4 visible in ack clock", s2, VECS[k].expv);
            bus_stop();
            check("R6 register outputs", outs(), VECS[k].expv);
        end

        // R6 field decode on last value 0x5A
        check("R6 divider bits", div, 2'b10);
        check("R6 data enable", den, 1'b0);
        check("R6 power-down", pd, 1'b1);

        // R3 read direction gets no ack
        bus_start();
        bus_byte({ADDR, 1'b1}, a1, s1);
        bus_byte(8'h11, a2, s2);
        bus_stop();
        check("R3 read bit no ack", a1, 1'b0);
        check("R3 read bit unchanged", outs(), 8'h5A);

        // R5 stop mid byte
        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        scl = 1'b0; waitc(Q);
        bus_stop();
        check("R5 stop discards", outs(), 8'h5A);

        // R5 R2 repeated start mid byte, then a full write
        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        for (int i = 0; i < 5; i++) bus_bit(1'b0);
        check("R5 restart discards", outs(), 8'h5A);
        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        bus_byte(8'hC4, a2, s2);
        bus_stop();
        check("R2 repeated start write", outs(), 8'hC4);

        // R8 extra byte ignored
        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        bus_byte(8'h10, a2, s2);
        bus_byte(8'hEF, a2, s2);
        check("R8 extra byte no ack", a2, 1'b0);
        bus_stop();
        check("R8 extra byte ignored", outs(), 8'h10);

        // R7 warm reset self-clear
        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        bus_byte(8'h02, a2, s2);
        bus_stop();
        check("R7 warm set", warm, 1'b1);
        pulse(sread);
        check("R7 read without event keeps", warm, 1'b1);
        pulse(ans);
        check("R7 event alone keeps", warm, 1'b1);
        pulse(sread);
        check("R7 answer then read clears", outs(), 8'h00);

        bus_start();
        bus_byte({ADDR, 1'b0}, a1, s1);
        bus_byte(8'h03, a2, s2);
        bus_stop();
        pulse(mute);
        pulse(sread);
        check("R7 mute then read clears", outs(), 8'h01);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule